// File: doc/BRIEF.md
# Serial Frame CRC-16 Generator and Checker

This block keeps the 16-bit check value of a serial RTU-style frame, one data byte at a time. The check register starts every frame at all ones. Each accepted byte is folded into the low end of the register. The register then shifts toward the least significant bit for eight steps. After any step whose outgoing bit was 1, the reflected polynomial is applied. Start, stop and parity bits are removed upstream, so only the eight data bits of each character reach this block.

On the transmit side, the payload bytes are fed in and the final value is read from `crc_value`. It is sent after the payload as two bytes: bits 7:0 first, then bits 15:8. On the receive side, the payload is fed in followed by the two received check bytes, in that same order. A correct frame leaves the register at zero. The frame-end strobe then latches the mismatch flag, so a nonzero register raises `crc_error`.

The default build performs one shift step per clock and shows `busy` while the steps run. The parameter `BITS_PER_CLK` can select a wider step chain that finishes a byte in fewer cycles.

Top module: `frame_crc16`

## Requirements
- R1: After reset, and in the cycle after a `frame_start` pulse, `crc_value` is 0xFFFF and `crc_error` is 0.
- R2: A single byte B accepted after the preset leaves `crc_value` equal to the result of these steps: XOR B into bits 7:0, then repeat eight times: shift right by one with a 0 into bit 15, and XOR with 0xA001 when the bit shifted out was 1.
- R3: The bytes of the ASCII string "123456789", accepted in order after the preset, leave `crc_value` at 0x4B37.
- R4: A byte is accepted when `byte_valid` is high, `busy` is low and `frame_start` is low. `busy` then stays high for exactly DATA_W/BITS_PER_CLK cycles, which is 8 in the default build. The result is on `crc_value` once `busy` falls.
- R5: A `byte_valid` pulse while `busy` is high is ignored and does not change the result.
- R6: While `busy` is low and no byte or `frame_start` arrives, `crc_value` holds its value.
- R7: A payload followed by its own check value, sent as bits 7:0 first and then bits 15:8, leaves `crc_value` at 0x0000. The next `frame_end` leaves `crc_error` at 0.
- R8: If any byte of such a frame is corrupted, `crc_error` is 1 after `frame_end`.
- R9: `crc_error` changes only on a `frame_end` accepted while `busy` is low, on `frame_start`, or on reset.
- R10: When `frame_start` and `byte_valid` are high in the same cycle, the register is preset and the byte is discarded.
- R11: A `frame_end` pulse while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Synchronous frame clear: presets the register and clears the error flag |
| byte_valid | input | 1 | Data byte strobe |
| byte_data | input | DATA_W | Data bits of one character |
| frame_end | input | 1 | Latches the mismatch flag from the current register value |
| busy | output | 1 | Shift steps of the last byte are still in progress |
| crc_value | output | CRC_W | Current check register |
| crc_error | output | 1 | Receive mismatch flag |

## Verification
The bench builds two copies of the block side by side. One uses the default one-step-per-clock chain. The other sets `BITS_PER_CLK` to 8, so each byte is processed in a single cycle. Because the data width is only eight bits, every possible byte value can be swept through both copies from the preset, and each result is compared with an arithmetic model. Frames of every length from 1 to 24 bytes are then run with their appended check bytes, both intact and corrupted. Both step chains therefore face the same residue and mismatch cases, together with the cycle-level corner cases of busy windows, ignored strobes and clear priority.

// File: rtl/crc16_pkg.sv
package crc16_pkg;
   localparam int unsigned   CRC16_W    = 16;
   localparam logic [15:0]   CRC16_POLY = 16'hA001;
   localparam logic [15:0]   CRC16_SEED = 16'hFFFF;
   typedef logic [CRC16_W-1:0] crc16_t;
endpackage

// File: rtl/crc_step_chain.sv
module crc_step_chain #(
   parameter int unsigned   WIDTH = 16,
   parameter int unsigned   STEPS = 1,
   parameter logic [WIDTH-1:0] POLY = 16'hA001
) (
   input  logic [WIDTH-1:0] d_in,
   output logic [WIDTH-1:0] d_out
);
   logic [WIDTH-1:0] stage [STEPS+1];

   assign stage[0] = d_in;

   for (genvar g = 0; g < STEPS; g++) begin : g_step
      always_comb begin
         if (stage[g][0]) stage[g+1] = (stage[g] >> 1) ^ POLY;
         else             stage[g+1] = stage[g] >> 1;
      end
   end

   assign d_out = stage[STEPS];
endmodule

// File: rtl/crc_seq_ctrl.sv
module crc_seq_ctrl #(
   parameter int unsigned CYCLES = 8,
   localparam int unsigned CNT_W = $clog2(CYCLES + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic accept,
   output logic busy,
   output logic step_en
);
   logic [CNT_W-1:0] remaining;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                remaining <= '0;
      else if (clr)              remaining <= '0;
      else if (accept)           remaining <= CNT_W'(CYCLES);
      else if (remaining != '0)  remaining <= remaining - 1'b1;
   end

   assign busy    = (remaining != '0);
   assign step_en = busy;
endmodule

// File: rtl/frame_crc16.sv
module frame_crc16 #(
   parameter int unsigned      CRC_W        = crc16_pkg::CRC16_W,
   parameter int unsigned      DATA_W       = 8,
   parameter int unsigned      BITS_PER_CLK = 1,
   parameter logic [CRC_W-1:0] POLY         = crc16_pkg::CRC16_POLY,
   parameter logic [CRC_W-1:0] INIT         = crc16_pkg::CRC16_SEED
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_start,
   input  logic              byte_valid,
   input  logic [DATA_W-1:0] byte_data,
   input  logic              frame_end,
   output logic              busy,
   output logic [CRC_W-1:0]  crc_value,
   output logic              crc_error
);
   localparam int unsigned CYCLES = DATA_W / BITS_PER_CLK;

   if (BITS_PER_CLK == 0 || (DATA_W % BITS_PER_CLK) != 0) begin : g_bad_step
      $error("frame_crc16: BITS_PER_CLK must divide DATA_W");
   end
   if (DATA_W > CRC_W) begin : g_bad_width
      $error("frame_crc16: DATA_W must not exceed CRC_W");
   end

   logic             accept;
   logic             step_en;
   logic [CRC_W-1:0] crc_q;
   logic [CRC_W-1:0] stepped;

   assign accept = byte_valid && !busy && !frame_start;

   crc_seq_ctrl #(.CYCLES(CYCLES)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (frame_start),
      .accept  (accept),
      .busy    (busy),
      .step_en (step_en)
   );

   crc_step_chain #(.WIDTH(CRC_W), .STEPS(BITS_PER_CLK), .POLY(POLY)) u_chain (
      .d_in  (crc_q),
      .d_out (stepped)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           crc_q <= INIT;
      else if (frame_start) crc_q <= INIT;
      else if (accept)      crc_q <= crc_q ^ CRC_W'(byte_data);
      else if (step_en)     crc_q <= stepped;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  crc_error <= 1'b0;
      else if (frame_start)        crc_error <= 1'b0;
      else if (frame_end && !busy) crc_error <= (crc_q != '0);
   end

   assign crc_value = crc_q;
endmodule

// File: rtl/frame_crc16_chk.sv
module frame_crc16_chk #(
   parameter int unsigned      CRC_W        = 16,
   parameter int unsigned      DATA_W       = 8,
   parameter int unsigned      BITS_PER_CLK = 1,
   parameter logic [CRC_W-1:0] INIT         = 16'hFFFF
) (
   input logic             clk,
   input logic             rst_n,
   input logic             frame_start,
   input logic             byte_valid,
   input logic             frame_end,
   input logic             busy,
   input logic [CRC_W-1:0] crc_value,
   input logic             crc_error
);
   localparam int unsigned CYCLES = DATA_W / BITS_PER_CLK;

   logic [15:0] busy_run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    busy_run <= '0;
      else if (busy) busy_run <= busy_run + 1'b1;
      else           busy_run <= '0;
   end

   p_reset_value_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (crc_value == INIT && !crc_error));

   p_start_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
      frame_start |=> (crc_value == INIT && !crc_error && !busy));

   p_accept_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_valid && !busy && !frame_start) |=> busy);

   p_busy_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (busy_run < 16'(CYCLES)));

   p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !byte_valid && !frame_start) |=> $stable(crc_value));

   p_err_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_end && !frame_start) |=> $stable(crc_error));

   p_end_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && frame_end && !frame_start) |=> $stable(crc_error));
endmodule

bind frame_crc16 frame_crc16_chk #(
   .CRC_W(CRC_W), .DATA_W(DATA_W), .BITS_PER_CLK(BITS_PER_CLK), .INIT(INIT)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .frame_start (frame_start),
   .byte_valid  (byte_valid),
   .frame_end   (frame_end),
   .busy        (busy),
   .crc_value   (crc_value),
   .crc_error   (crc_error)
);

// File: tb/frame_crc16_test.sv
module frame_crc16_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fs = 1'b0, bv = 1'b0, bvp = 1'b0, fe = 1'b0;
   logic [7:0]  bd = 8'h00;
   logic        busy, busy_p, err, err_p;
   logic [15:0] crc, crc_p;
   int          checks = 0, fails = 0;
   bit          finished = 1'b0;

   always #5 clk = ~clk;

   frame_crc16 uut (
      .clk(clk), .rst_n(rst_n), .frame_start(fs), .byte_valid(bv), .byte_data(bd),
      .frame_end(fe), .busy(busy), .crc_value(crc), .crc_error(err));

   frame_crc16 #(.BITS_PER_CLK(8)) uut_par (
      .clk(clk), .rst_n(rst_n), .frame_start(fs), .byte_valid(bvp), .byte_data(bd),
      .frame_end(fe), .busy(busy_p), .crc_value(crc_p), .crc_error(err_p));

   function automatic logic [15:0] model(input logic [15:0] c, input logic [7:0] b);
      logic [15:0] r = c ^ {8'h00, b};
      for (int k = 0; k < 8; k++) r = r[0] ? ((r >> 1) ^ 16'hA001) : (r >> 1);
      return r;
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wait_idle();
      while (busy || busy_p) @(negedge clk);
   endtask

   task automatic start_frame();
      @(negedge clk); fs = 1'b1;
      @(negedge clk); fs = 1'b0;
   endtask

   task automatic send_byte(input logic [7:0] b);
      @(negedge clk); bd = b; bv = 1'b1; bvp = 1'b1;
      @(negedge clk); bv = 1'b0; bvp = 1'b0;
      wait_idle();
   endtask

   task automatic end_frame();
      @(negedge clk); fe = 1'b1;
      @(negedge clk); fe = 1'b0;
   endtask

   function automatic logic [7:0] pat(input int len, input int i);
      return 8'((i * 37 + len * 11 + 5) & 255);
   endfunction

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         fails++; checks++;
         $display("FAIL watchdog actual hung expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [15:0] m, hold;
      int n;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 reset crc", crc, 16'hFFFF);
      chk("R1 reset err", err, 0);
      chk("R1 reset busy", busy, 0);
      chk("R1 reset crc par", crc_p, 16'hFFFF);
      rst_n = 1'b1;
      @(negedge clk);

      // R2 exhaustive single byte sweep on both step chains
      for (int b = 0; b < 256; b++) begin
         start_frame();
         send_byte(8'(b));
         chk("R2 single byte", crc, model(16'hFFFF, 8'(b)));
         chk("R2 single byte par", crc_p, model(16'hFFFF, 8'(b)));
      end

      // R3 known vector
      start_frame();
      for (int i = 0; i < 9; i++) send_byte(8'h31 + 8'(i));
      chk("R3 vector", crc, 16'h4B37);
      chk("R3 vector par", crc_p, 16'h4B37);

      // R6 idle hold
      hold = crc;
      repeat (6) @(negedge clk);
      chk("R6 idle hold", crc, hold);

      // R4 busy window length
      start_frame();
      @(negedge clk); bd = 8'hC3; bv = 1'b1;
      @(negedge clk); bv = 1'b0; n = 0;
      while (busy) begin n++; @(negedge clk); end
      chk("R4 busy cycles", n, 8);
      chk("R4 result after busy", crc, model(16'hFFFF, 8'hC3));
      @(negedge clk); bvp = 1'b1;
      @(negedge clk); bvp = 1'b0; n = 0;
      while (busy_p) begin n++; @(negedge clk); end
      chk("R4 busy cycles par", n, 1);

      // R5 byte while busy ignored
      start_frame();
      @(negedge clk); bd = 8'h5A; bv = 1'b1; bvp = 1'b1;
      @(negedge clk); bvp = 1'b0; bd = 8'hFF;
      chk("R5 busy seen", busy, 1);
      @(negedge clk); bv = 1'b0;
      wait_idle();
      chk("R5 ignored byte", crc, model(16'hFFFF, 8'h5A));

      // R10 clear wins over byte
      send_byte(8'h11);
      @(negedge clk); fs = 1'b1; bv = 1'b1; bvp = 1'b1; bd = 8'h31;
      @(negedge clk); fs = 1'b0; bv = 1'b0; bvp = 1'b0;
      repeat (3) @(negedge clk);
      chk("R10 byte dropped", crc, 16'hFFFF);
      chk("R10 byte dropped par", crc_p, 16'hFFFF);
      chk("R10 not busy", busy, 0);

      // R7 / R8 frames of many lengths
      for (int len = 1; len <= 24; len++) begin
         m = 16'hFFFF;
         start_frame();
         for (int i = 0; i < len; i++) begin
            send_byte(pat(len, i));
            m = model(m, pat(len, i));
         end
         chk("R7 tx value", crc, m);
         send_byte(m[7:0]);
         send_byte(m[15:8]);
         chk("R7 residue", crc, 16'h0000);
         chk("R7 residue par", crc_p, 16'h0000);
         end_frame();
         chk("R7 no error", err, 0);
         chk("R7 no error par", err_p, 0);
         start_frame();
         for (int i = 0; i < len; i++)
            send_byte((i == len - 1) ? (pat(len, i) ^ 8'h04) : pat(len, i));
         send_byte(m[7:0]);
         send_byte(m[15:8]);
         end_frame();
         chk("R8 error", err, 1);
         chk("R8 error par", err_p, 1);
      end

      // R9 error holds without frame_end, clears on frame_start
      send_byte(8'h00);
      send_byte(8'h00);
      repeat (2) @(negedge clk);
      chk("R9 hold", err, 1);
      start_frame();
      chk("R9 cleared", err, 0);
      chk("R1 start preset", crc, 16'hFFFF);

      // R11 frame_end while busy ignored
      @(negedge clk); bd = 8'h01; bv = 1'b1; bvp = 1'b1;
      @(negedge clk); bv = 1'b0; bvp = 1'b0; fe = 1'b1;
      @(negedge clk); fe = 1'b0;
      chk("R11 busy end ignored", err, 0);
      wait_idle();
      chk("R11 err still low", err, 0);
      end_frame();
      chk("R11 later end", err, (model(16'hFFFF, 8'h01) != 0) ? 1 : 0);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule